// File: doc/BRIEF.md
# Active Miller Clamp Controller

This block holds the digital control for a gate-driver output stage built from three switches: a pull-up, a main pull-down and a separate clamp pull-down that keeps the power-switch gate low. Its inputs are a drive command, which has already been filtered and is synchronous to the block clock, and a comparator flag that is asynchronous to that clock. The flag reports that the sensed gate voltage is below the clamp threshold. Its outputs are one enable for each switch.

The drive command selects between the pull-up and the main pull-down. Whenever the command changes, a break cycle with every switch off is inserted first. The clamp can engage only while the gate is being pulled low and the synchronised flag is asserted. When the gate voltage briefly swings back above the threshold, a qualification timer keeps the clamp engaged. The clamp releases only after the flag has stayed deasserted for a full filter time, or at once when the drive command goes high. The filter length is a parameter in clock cycles: 20 cycles at 50 MHz gives 400 ns.

Top module: `miller_clamp_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after any clock edge with reset high, the enables pu_en, pd_en and clamp_en are all 0.
- R2: After drive_cmd rises, the first clock edge that samples it turns every enable off. The next edge sets pu_en alone, and pu_en stays set while the command remains high.
- R3: After drive_cmd falls, the first edge that samples it turns every enable off. The next edge sets pd_en, and pu_en stays 0 while the command remains low.
- R4: pu_en is never set in the same cycle as pd_en or clamp_en. Every change of the sampled command produces at least one cycle with all enables at 0, and a command that reverses during that break cycle extends the break by one more cycle.
- R5: clamp_en is set only together with pd_en, and only after the synchronised flag has been seen asserted. It stays 0 while the flag is deasserted or the command is high.
- R6: The flag passes through a two-flop synchroniser. A flag raised just after an edge engages the clamp after the third following edge, and not earlier.
- R7: Once engaged, the clamp stays on through a deassertion of the flag that lasts fewer than FILT_CYC clock cycles.
- R8: When the flag stays deasserted for FILT_CYC or more cycles, the clamp releases at the (FILT_CYC+2)-th edge after the flag fell.
- R9: Any reassertion of the flag restarts the deassertion count. Two deassertions of FILT_CYC-1 cycles each, separated by one cycle of assertion, do not release the clamp.
- R10: When the command goes high, the clamp turns off at the first edge that samples the command, in the same cycle as pd_en.
- R11: When the command goes low while the synchronised flag is already asserted, clamp_en is set in the same cycle as pd_en.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| drive_cmd | input | 1 | Filtered drive command: 1 means pull the gate high |
| gate_low_async | input | 1 | Asynchronous comparator flag: gate voltage below the clamp threshold |
| pu_en | output | 1 | Pull-up switch enable |
| pd_en | output | 1 | Main pull-down switch enable |
| clamp_en | output | 1 | Clamp pull-down switch enable |

## Verification
A wrong sequencer state shows at the ports within two edges of a command change, either as a missing break cycle or as the wrong side turning on. A miscounted qualification timer shows as a clamp release that comes one or more cycles too early or too late relative to the FILT_CYC+2 edge window. The bench therefore runs every deassertion length from 1 to FILT_CYC+2 with a small filter and checks each cycle. A synchroniser with the wrong depth moves the clamp turn-on edge by a cycle and is caught on the first engagement.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

    typedef enum logic [1:0] {
        DM_BREAK = 2'd0,
        DM_HIGH  = 2'd1,
        DM_LOW   = 2'd2
    } drv_mode_t;

    typedef struct packed {
        logic pu;
        logic pd;
        logic clamp;
    } sw_en_t;

    function automatic sw_en_t decode_sw(drv_mode_t mode, logic clamp_on);
        sw_en_t s;
        s.pu    = (mode == DM_HIGH);
        s.pd    = (mode == DM_LOW);
        s.clamp = (mode == DM_LOW) && clamp_on;
        return s;
    endfunction

    function automatic drv_mode_t side_of(logic cmd);
        return cmd ? DM_HIGH : DM_LOW;
    endfunction

endpackage

// File: rtl/mcc_sync.sv
module mcc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d_async;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d_async};
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/mcc_drive_seq.sv
module mcc_drive_seq
    import mcc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      drive_cmd,
    output drv_mode_t mode_q,
    output drv_mode_t mode_d
);
    logic tgt_q;
    logic tgt_d;

    always_comb begin
        tgt_d  = tgt_q;
        mode_d = mode_q;
        if (drive_cmd != tgt_q) begin
            tgt_d  = drive_cmd;
            mode_d = DM_BREAK;
        end else if (mode_q == DM_BREAK) begin
            mode_d = side_of(drive_cmd);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tgt_q  <= 1'b0;
            mode_q <= DM_BREAK;
        end else begin
            tgt_q  <= tgt_d;
            mode_q <= mode_d;
        end
    end
endmodule

// File: rtl/mcc_clamp_filter.sv
module mcc_clamp_filter #(
    parameter int FILT_CYC = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic gate_low_s,
    output logic clamp_q
);
    localparam int CW = (FILT_CYC > 2) ? $clog2(FILT_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            clamp_q <= 1'b0;
            cnt_q   <= '0;
        end else if (!arm) begin
            clamp_q <= 1'b0;
            cnt_q   <= '0;
        end else if (gate_low_s) begin
            clamp_q <= 1'b1;
            cnt_q   <= '0;
        end else if (clamp_q) begin
            if (cnt_q == LAST) begin
                clamp_q <= 1'b0;
                cnt_q   <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/miller_clamp_ctrl.sv
module miller_clamp_ctrl
    import mcc_pkg::*;
#(
    parameter int FILT_CYC    = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic drive_cmd,
    input  logic gate_low_async,
    output logic pu_en,
    output logic pd_en,
    output logic clamp_en
);
    logic      gate_low_s;
    drv_mode_t mode_q;
    drv_mode_t mode_d;
    logic      clamp_q;
    sw_en_t    sw;

    mcc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .d_async(gate_low_async),
        .q_sync (gate_low_s)
    );

    mcc_drive_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .drive_cmd(drive_cmd),
        .mode_q   (mode_q),
        .mode_d   (mode_d)
    );

    mcc_clamp_filter #(.FILT_CYC(FILT_CYC)) u_filt (
        .clk       (clk),
        .rst       (rst),
        .arm       (mode_d == DM_LOW),
        .gate_low_s(gate_low_s),
        .clamp_q   (clamp_q)
    );

    assign sw       = decode_sw(mode_q, clamp_q);
    assign pu_en    = sw.pu;
    assign pd_en    = sw.pd;
    assign clamp_en = sw.clamp;
endmodule

// File: rtl/mcc_checker.sv
module mcc_checker #(
    parameter int FILT_CYC = 20
) (
    input logic clk,
    input logic rst,
    input logic drive_cmd,
    input logic gate_low_s,
    input logic pu_en,
    input logic pd_en,
    input logic clamp_en
);
    localparam int RW = $clog2(FILT_CYC + 1);
    localparam logic [RW-1:0] FULL = RW'(FILT_CYC);

    logic [RW-1:0] low_run;

    always_ff @(posedge clk) begin
        if (rst)                low_run <= '0;
        else if (gate_low_s)    low_run <= '0;
        else if (low_run != FULL) low_run <= low_run + 1'b1;
    end

    assert_reset_off_R1: assert property (@(posedge clk)
        rst |=> (!pu_en && !pd_en && !clamp_en));

    assert_pu_follows_cmd_R2: assert property (@(posedge clk) disable iff (rst)
        pu_en |-> $past(drive_cmd));

    assert_pd_follows_cmd_R3: assert property (@(posedge clk) disable iff (rst)
        pd_en |-> !$past(drive_cmd));

    assert_no_overlap_R4: assert property (@(posedge clk) disable iff (rst)
        !(pu_en && (pd_en || clamp_en)));

    assert_break_before_pu_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(pu_en) |-> $past(!pd_en && !clamp_en));

    assert_break_before_pd_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(pd_en) |-> $past(!pu_en));

    assert_clamp_with_pd_R5: assert property (@(posedge clk) disable iff (rst)
        clamp_en |-> pd_en);

    assert_clamp_needs_flag_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(clamp_en) |-> $past(gate_low_s));

    assert_release_qualified_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(clamp_en) |-> ($past(drive_cmd) || (low_run == FULL)));
endmodule

bind miller_clamp_ctrl mcc_checker #(.FILT_CYC(FILT_CYC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .drive_cmd (drive_cmd),
    .gate_low_s(gate_low_s),
    .pu_en     (pu_en),
    .pd_en     (pd_en),
    .clamp_en  (clamp_en)
);

// File: tb/miller_clamp_ctrl_test.sv
module miller_clamp_ctrl_test;
    localparam int FILT = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic drive_cmd = 1'b0;
    logic gate_low_async = 1'b0;
    logic pu_en, pd_en, clamp_en;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    miller_clamp_ctrl #(.FILT_CYC(FILT), .SYNC_STAGES(2)) uut (
        .clk           (clk),
        .rst           (rst),
        .drive_cmd     (drive_cmd),
        .gate_low_async(gate_low_async),
        .pu_en         (pu_en),
        .pd_en         (pd_en),
        .clamp_en      (clamp_en)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [2:0] exp);
        logic [2:0] act;
        act = {pu_en, pd_en, clamp_en};
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: pu/pd/clamp=%b expected %b", req, act, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        // R1: reset holds every enable low
        tick(); tick(); tick();
        chk("R1 reset", 3'b000);
        rst = 1'b0;
        tick();
        chk("R3 low after reset", 3'b010);
        for (int i = 0; i < 8; i++) begin
            tick();
            chk("R5 no flag no clamp", 3'b010);
        end

        // R6: clamp engages on the third edge after the flag rises
        gate_low_async = 1'b1;
        tick(); chk("R6 sync stage 1", 3'b010);
        tick(); chk("R6 sync stage 2", 3'b010);
        tick(); chk("R6 clamp on", 3'b011);

        // R7/R8: sweep deassertion lengths
        for (int g = 1; g <= FILT + 2; g++) begin
            gate_low_async = 1'b0;
            for (int t = 1; t <= g + 5; t++) begin
                bit on;
                tick();
                on = (g < FILT) || (t < FILT + 2) || (t >= g + 3);
                if (g < FILT) chk("R7 hold through short gap", {2'b01, on});
                else          chk("R8 release after full gap", {2'b01, on});
                if (t == g) gate_low_async = 1'b1;
            end
        end

        // R9: reassertion restarts the count
        gate_low_async = 1'b0;
        for (int t = 1; t <= 2 * FILT + 4; t++) begin
            tick();
            chk("R9 restart count", 3'b011);
            if (t == FILT - 1)     gate_low_async = 1'b1;
            if (t == FILT)         gate_low_async = 1'b0;
            if (t == 2 * FILT - 1) gate_low_async = 1'b1;
        end

        // R10/R2: command high drops clamp at once, pull-up after break
        drive_cmd = 1'b1;
        tick(); chk("R10 clamp off on cmd high", 3'b000);
        tick(); chk("R2 pull-up on", 3'b100);
        for (int i = 0; i < 4; i++) begin
            tick(); chk("R5 no clamp while high", 3'b100);
        end

        // R11: low with flag already asserted
        drive_cmd = 1'b0;
        tick(); chk("R3 break", 3'b000);
        tick(); chk("R11 clamp with pd", 3'b011);

        // R4: reversal inside break cycle
        drive_cmd = 1'b1;
        tick(); chk("R4 break", 3'b000);
        drive_cmd = 1'b0;
        tick(); chk("R4 extended break", 3'b000);
        tick(); chk("R4 back low", 3'b011);

        // R3/R5: low without flag keeps clamp off
        drive_cmd = 1'b1;
        tick(); chk("R4 break", 3'b000);
        tick(); chk("R2 pull-up", 3'b100);
        gate_low_async = 1'b0;
        tick(); tick(); tick(); tick();
        drive_cmd = 1'b0;
        tick(); chk("R4 break", 3'b000);
        for (int i = 0; i < 4; i++) begin
            tick(); chk("R5 pd only", 3'b010);
        end

        // R1: reset in mid operation
        drive_cmd = 1'b1;
        tick(); tick(); chk("R2 pull-up", 3'b100);
        rst = 1'b1;
        tick(); chk("R1 reset mid run", 3'b000);
        rst = 1'b0;

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule